// File: doc/BRIEF.md
# NAND Single-Bit ECC Engine

This block produces and evaluates a 24-bit Hamming-style check code for NAND flash data units of 512 bytes. Data bytes arrive on a byte-wide stream with a valid strobe and a context selector. Up to four accumulator contexts are kept, one for each flash chip select. A context only accumulates after it has been started. Reading its code hands back the packed result and clears that context.

The packed code is the bitwise inverse of two 12-bit parity halves. Because of the inversion, an erased unit of all-ones data and an all-ones stored code check as clean. A separate compare path takes a code read from flash and a code freshly computed over the same data. It returns one of three outcomes: clean, corrected or uncorrectable. For a correctable data error it also returns the byte offset and bit position to flip.

Top module: `nand_ecc1b`

## Requirements
- R1: After reset every context is disabled (`ctx_en_o` all zero), `rd_valid_o` and `cmp_valid_o` are low, and reading any context returns 24'hFFFFFF.
- R2: The code read from a context is the bitwise inverse of {HI, LO}, with HI in bits 23:12 and LO in bits 11:0. Each accepted data bit has a 12-bit index: its byte offset since the restart in bits 11:3 and its bit number in bits 2:0. HI bit k is the XOR of all set data bits whose index has bit k set. LO bit k is the XOR of all set data bits whose index has bit k clear. So 512 bytes of 8'hFF give 24'hFFFFFF.
- R3: `start_i` with `start_ctx_i` clears that context's parities and byte count and enables it. Its `ctx_en_o` bit is high from the next cycle on.
- R4: A byte is taken only when `byte_valid_i` is high, `byte_ctx_i` names an enabled context, and that context has taken fewer than 512 bytes since its restart. Every other byte leaves the context's code unchanged.
- R5: `rd_i` with `rd_ctx_i` puts that context's code on `rd_code_o`, with `rd_valid_o` high, one cycle later. It also clears and disables the context. A byte for the same context in the same cycle is dropped. If a start for the same context comes in the same cycle, the old code is returned and the context ends up enabled and empty.
- R6: Contexts are independent: bytes, starts and reads aimed at one context never change another context's code or enable.
- R7: The compare path answers one cycle after `cmp_valid_i`, with `cmp_valid_o` high. A syndrome (stored XOR calculated) of zero gives status 0 (clean).
- R8: A syndrome whose bits 23:12 are the exact complement of its bits 11:0 gives status 1 (corrected). The byte offset is syndrome bits 23:15 and the bit position is syndrome bits 14:12.
- R9: A syndrome with exactly one bit set gives status 0, because the error lies in the stored code and the data is good.
- R10: Any other nonzero syndrome gives status 2 (uncorrectable). Whenever the status is not 1, `cmp_byte_o` and `cmp_bit_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Restart and enable a context |
| start_ctx_i | input | 2 | Context to restart |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_ctx_i | input | 2 | Context the byte belongs to |
| byte_i | input | 8 | Data byte |
| rd_i | input | 1 | Read and clear a context |
| rd_ctx_i | input | 2 | Context to read |
| rd_valid_o | output | 1 | Code valid on rd_code_o |
| rd_code_o | output | 24 | Packed inverted code |
| ctx_en_o | output | 4 | Per-context accumulate enable |
| cmp_valid_i | input | 1 | Compare request |
| cmp_stored_i | input | 24 | Code read from flash |
| cmp_calc_i | input | 24 | Freshly computed code |
| cmp_valid_o | output | 1 | Compare result valid |
| cmp_status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| cmp_byte_o | output | 9 | Byte offset to fix |
| cmp_bit_o | output | 3 | Bit within the byte to fix |

## Verification
A bad parity half or a bad byte counter inside a context stays hidden until that context is read. It then shows as a wrong code on the read that follows, and a corrupt counter shows as a wrong byte offset once a single-bit fault is reconstructed through the compare path. A stuck or leaking enable shows as a nonzero code read from a context that should have ignored its bytes. The sweeps walk every 12-bit error index and every one-hot syndrome, so a wrong decode is seen on the first cycle after the request.

// File: rtl/nand_ecc1b_pkg.sv
package nand_ecc1b_pkg;

    // Outcome of comparing a stored code with a freshly computed one
    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_status_e;

endpackage

// File: rtl/nand_ecc1b_term.sv
// Parity contribution of one data byte at a given offset within the unit.
module nand_ecc1b_term #(
    parameter  int ADDR_W = 9,
    localparam int IDX_W  = ADDR_W + 3
) (
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [7:0]        data_i,
    output logic [IDX_W-1:0]  odd_o,
    output logic [IDX_W-1:0]  even_o
);

    logic [IDX_W-1:0] odd_part  [8];
    logic [IDX_W-1:0] even_part [8];

    // Each set bit folds its own index into HI and the complement into LO
    for (genvar j = 0; j < 8; j++) begin : g_bit
        logic [IDX_W-1:0] idx;
        assign idx          = {offset_i, 3'(j)};
        assign odd_part[j]  = data_i[j] ? idx  : '0;
        assign even_part[j] = data_i[j] ? ~idx : '0;
    end

    always_comb begin
        odd_o  = '0;
        even_o = '0;
        for (int k = 0; k < 8; k++) begin
            odd_o  = odd_o  ^ odd_part[k];
            even_o = even_o ^ even_part[k];
        end
    end

endmodule

// File: rtl/nand_ecc1b_ctx.sv
// One accumulator context: enable, byte count and the two parity halves.
module nand_ecc1b_ctx #(
    parameter  int UNIT_BYTES = 512,
    localparam int ADDR_W     = $clog2(UNIT_BYTES),
    localparam int IDX_W      = ADDR_W + 3,
    localparam int CNT_W      = $clog2(UNIT_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rd_i,
    input  logic               byte_en_i,
    input  logic [7:0]         data_i,
    output logic [2*IDX_W-1:0] code_o,
    output logic               en_o
);

    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(UNIT_BYTES);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] odd;
        logic [IDX_W-1:0] even;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic [IDX_W-1:0] term_odd, term_even;
    logic             room;

    assign room = ctx_q.cnt < CNT_LIM;

    nand_ecc1b_term #(.ADDR_W(ADDR_W)) u_term (
        .offset_i (ctx_q.cnt[ADDR_W-1:0]),
        .data_i   (data_i),
        .odd_o    (term_odd),
        .even_o   (term_even)
    );

    always_comb begin
        ctx_d = ctx_q;
        if (byte_en_i && ctx_q.en && room) begin
            ctx_d.odd  = ctx_q.odd  ^ term_odd;
            ctx_d.even = ctx_q.even ^ term_even;
            ctx_d.cnt  = ctx_q.cnt + CNT_W'(1);
        end
        // A read discards any byte of the same cycle and disables
        if (rd_i) begin
            ctx_d = '0;
        end
        // A restart wins over the read's disable
        if (start_i) begin
            ctx_d    = '0;
            ctx_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign code_o = ~{ctx_q.odd, ctx_q.even};
    assign en_o   = ctx_q.en;

    // R3: a restart leaves an enabled, empty context
    a_r3_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (en_o && ctx_q.cnt == '0 && code_o == '1));

    // R5: a read without restart clears and disables
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !start_i) |=> (!en_o && ctx_q.cnt == '0 && code_o == '1));

    // R4: a disabled context never changes its code without a restart
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !start_i) |=> $stable(code_o));

    // R4: the byte count never passes the unit size
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.cnt <= CNT_LIM);

endmodule

// File: rtl/nand_ecc1b_check.sv
// Syndrome decode of a stored code against a computed code.
module nand_ecc1b_check
    import nand_ecc1b_pkg::*;
#(
    parameter  int UNIT_BYTES = 512,
    localparam int ADDR_W     = $clog2(UNIT_BYTES),
    localparam int IDX_W      = ADDR_W + 3,
    localparam int CODE_W     = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] stored_i,
    input  logic [CODE_W-1:0] calc_i,
    output logic              valid_o,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] byte_o,
    output logic [2:0]        bit_o
);

    localparam logic [ADDR_W:0] UNIT_LIM = (ADDR_W + 1)'(UNIT_BYTES);

    typedef struct packed {
        logic              vld;
        ecc_status_e       st;
        logic [ADDR_W-1:0] byt;
        logic [2:0]        bitn;
    } chk_t;

    chk_t chk_q, chk_d;

    logic [CODE_W-1:0] syn;
    logic [IDX_W-1:0]  hi, lo;

    assign syn = stored_i ^ calc_i;
    assign hi  = syn[CODE_W-1:IDX_W];
    assign lo  = syn[IDX_W-1:0];

    always_comb begin
        chk_d     = '0;
        chk_d.st  = ECC_CLEAN;
        chk_d.vld = valid_i;
        if (valid_i) begin
            if (syn == '0) begin
                chk_d.st = ECC_CLEAN;
            end else if ((hi ^ lo) == '1) begin
                if ({1'b0, hi[IDX_W-1:3]} < UNIT_LIM) begin
                    chk_d.st   = ECC_FIXED;
                    chk_d.byt  = hi[IDX_W-1:3];
                    chk_d.bitn = hi[2:0];
                end else begin
                    chk_d.st = ECC_FATAL;
                end
            end else if ($onehot(syn)) begin
                chk_d.st = ECC_CLEAN;
            end else begin
                chk_d.st = ECC_FATAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q    <= '0;
            chk_q.st <= ECC_CLEAN;
        end else begin
            chk_q <= chk_d;
        end
    end

    assign valid_o  = chk_q.vld;
    assign status_o = chk_q.st;
    assign byte_o   = chk_q.byt;
    assign bit_o    = chk_q.bitn;

    // R7: one-cycle answer
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R10: location is zero unless a fix is reported
    a_r10_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd1) |-> (byte_o == '0 && bit_o == '0));

    // R10: only the three defined outcomes appear
    a_r10_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd3);

endmodule

// File: rtl/nand_ecc1b.sv
// Multi-context single-bit ECC engine for NAND data units.
module nand_ecc1b #(
    parameter  int NUM_CTX    = 4,
    parameter  int UNIT_BYTES = 512,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int ADDR_W     = $clog2(UNIT_BYTES),
    localparam int CODE_W     = 2 * (ADDR_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTX_W-1:0]  start_ctx_i,
    input  logic              byte_valid_i,
    input  logic [CTX_W-1:0]  byte_ctx_i,
    input  logic [7:0]        byte_i,
    input  logic              rd_i,
    input  logic [CTX_W-1:0]  rd_ctx_i,
    output logic              rd_valid_o,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [NUM_CTX-1:0] ctx_en_o,
    input  logic              cmp_valid_i,
    input  logic [CODE_W-1:0] cmp_stored_i,
    input  logic [CODE_W-1:0] cmp_calc_i,
    output logic              cmp_valid_o,
    output logic [1:0]        cmp_status_o,
    output logic [ADDR_W-1:0] cmp_byte_o,
    output logic [2:0]        cmp_bit_o
);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } rd_t;

    rd_t rd_q, rd_d;

    logic [CODE_W-1:0] ctx_code [NUM_CTX];
    logic [CODE_W-1:0] sel_code;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        logic start_hit, rd_hit, byte_hit;
        assign start_hit = start_i      && (start_ctx_i == CTX_W'(g));
        assign rd_hit    = rd_i         && (rd_ctx_i    == CTX_W'(g));
        assign byte_hit  = byte_valid_i && (byte_ctx_i  == CTX_W'(g));

        nand_ecc1b_ctx #(.UNIT_BYTES(UNIT_BYTES)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_hit),
            .rd_i      (rd_hit),
            .byte_en_i (byte_hit),
            .data_i    (byte_i),
            .code_o    (ctx_code[g]),
            .en_o      (ctx_en_o[g])
        );
    end

    assign sel_code = ctx_code[rd_ctx_i];

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd_i;
        if (rd_i) rd_d.code = sel_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '{vld: 1'b0, code: '1};
        else        rd_q <= rd_d;
    end

    assign rd_valid_o = rd_q.vld;
    assign rd_code_o  = rd_q.code;

    nand_ecc1b_check #(.UNIT_BYTES(UNIT_BYTES)) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (cmp_valid_i),
        .stored_i (cmp_stored_i),
        .calc_i   (cmp_calc_i),
        .valid_o  (cmp_valid_o),
        .status_o (cmp_status_o),
        .byte_o   (cmp_byte_o),
        .bit_o    (cmp_bit_o)
    );

    // R5: a read is answered in the next cycle with the selected code
    a_r5_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (rd_valid_o && rd_code_o == $past(sel_code)));

    // R5: no answer appears without a read
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rd_valid_o);

endmodule

// File: tb/nand_ecc1b_bench.sv
module nand_ecc1b_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  start_ctx_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [1:0]  byte_ctx_i = '0;
    logic [7:0]  byte_i = '0;
    logic        rd_i = 1'b0;
    logic [1:0]  rd_ctx_i = '0;
    logic        rd_valid_o;
    logic [23:0] rd_code_o;
    logic [3:0]  ctx_en_o;
    logic        cmp_valid_i = 1'b0;
    logic [23:0] cmp_stored_i = '0;
    logic [23:0] cmp_calc_i = '0;
    logic        cmp_valid_o;
    logic [1:0]  cmp_status_o;
    logic [8:0]  cmp_byte_o;
    logic [2:0]  cmp_bit_o;

    int total = 0;
    int bad   = 0;

    logic [7:0] mem [520];

    always #2 clk = ~clk;   // 250 MHz

    nand_ecc1b u_nand_ecc1b (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference code over the first n bytes of mem (capped at a unit)
    function automatic logic [23:0] model_code(input int n);
        logic [11:0] hi = '0;
        logic [11:0] lo = '0;
        for (int a = 0; a < n && a < 512; a++) begin
            for (int j = 0; j < 8; j++) begin
                if (mem[a][j]) begin
                    hi ^= 12'((a << 3) | j);
                    lo ^= ~12'((a << 3) | j);
                end
            end
        end
        return ~{hi, lo};
    endfunction

    function automatic void fill(input int seed);
        logic [15:0] s = 16'(seed * 40503 + 1);
        for (int i = 0; i < 520; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            if (s == 0) s = 16'h1;
            mem[i] = s[7:0] ^ 8'(i);
        end
    endfunction

    task automatic do_start(input int c);
        start_i = 1'b1; start_ctx_i = 2'(c);
        step();
        start_i = 1'b0;
    endtask

    task automatic send(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            byte_valid_i = 1'b1; byte_ctx_i = 2'(c); byte_i = mem[i];
            step();
        end
        byte_valid_i = 1'b0;
    endtask

    task automatic do_read(input int c, output logic [23:0] code);
        rd_i = 1'b1; rd_ctx_i = 2'(c);
        step();
        rd_i = 1'b0;
        chk(rd_valid_o == 1'b1, "R5 rd_valid", 32'(rd_valid_o), 32'd1);
        code = rd_code_o;
    endtask

    task automatic do_cmp(input logic [23:0] st, input logic [23:0] ca);
        cmp_valid_i = 1'b1; cmp_stored_i = st; cmp_calc_i = ca;
        step();
        cmp_valid_i = 1'b0;
        chk(cmp_valid_o == 1'b1, "R7 cmp_valid", 32'(cmp_valid_o), 32'd1);
    endtask

    // Decode expected from the requirement text
    task automatic exp_decode(input logic [23:0] syn, output logic [1:0] st, output logic [8:0] b, output logic [2:0] bt);
        st = 2'd2; b = '0; bt = '0;
        if (syn == 0) st = 2'd0;
        else if ((syn[23:12] ^ syn[11:0]) == 12'hFFF) begin
            st = 2'd1; b = syn[23:15]; bt = syn[14:12];
        end else if ($countones(syn) == 1) st = 2'd0;
    endtask

    task automatic cmp_and_check(input string tag, input logic [23:0] st_c, input logic [23:0] ca_c);
        logic [1:0] es; logic [8:0] eb; logic [2:0] et;
        exp_decode(st_c ^ ca_c, es, eb, et);
        do_cmp(st_c, ca_c);
        chk(cmp_status_o == es, {tag, " status"}, 32'(cmp_status_o), 32'(es));
        chk(cmp_byte_o == eb, {tag, " byte"}, 32'(cmp_byte_o), 32'(eb));
        chk(cmp_bit_o == et, {tag, " bit"}, 32'(cmp_bit_o), 32'(et));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [23:0] code, c0, c1, exp;
        repeat (3) step();
        // R1: reset state
        chk(ctx_en_o == 4'b0, "R1 ctx_en after reset", 32'(ctx_en_o), 32'd0);
        chk(rd_valid_o == 1'b0, "R1 rd_valid after reset", 32'(rd_valid_o), 32'd0);
        chk(cmp_valid_o == 1'b0, "R1 cmp_valid after reset", 32'(cmp_valid_o), 32'd0);
        rst_n = 1'b1;
        step();
        for (int c = 0; c < 4; c++) begin
            do_read(c, code);
            chk(code == 24'hFFFFFF, "R1 idle context code", 32'(code), 32'hFFFFFF);
        end

        // R3/R2: erased unit
        do_start(0);
        chk(ctx_en_o == 4'b0001, "R3 enable rises", 32'(ctx_en_o), 32'd1);
        for (int i = 0; i < 520; i++) mem[i] = 8'hFF;
        send(0, 512);
        do_read(0, code);
        chk(code == 24'hFFFFFF, "R2 erased unit", 32'(code), 32'hFFFFFF);
        chk(ctx_en_o[0] == 1'b0, "R5 read disables", 32'(ctx_en_o), 32'd0);

        // R2: single-bit patterns at a spread of offsets
        for (int p = 0; p < 4096; p += 331) begin
            for (int i = 0; i < 520; i++) mem[i] = 8'h00;
            mem[p >> 3][p & 7] = 1'b1;
            do_start(1);
            send(1, (p >> 3) + 1);
            do_read(1, code);
            exp = {~12'(p), 12'(p)};
            chk(code == exp, "R2 single bit code", 32'(code), 32'(exp));
        end

        // R2: dense patterns of several lengths
        for (int s = 1; s < 5; s++) begin
            fill(s);
            do_start(2);
            send(2, 64 * s + 7);
            do_read(2, code);
            exp = model_code(64 * s + 7);
            chk(code == exp, "R2 dense pattern code", 32'(code), 32'(exp));
        end

        // R4: bytes past the unit are ignored
        fill(9);
        do_start(3);
        send(3, 520);
        do_read(3, code);
        exp = model_code(512);
        chk(code == exp, "R4 bytes past unit dropped", 32'(code), 32'(exp));

        // R4: bytes to a disabled context are ignored
        send(1, 40);
        do_read(1, code);
        chk(code == 24'hFFFFFF, "R4 disabled context ignores", 32'(code), 32'hFFFFFF);

        // R6: interleaved contexts stay independent
        fill(21);
        do_start(0); do_start(3);
        for (int i = 0; i < 32; i++) begin
            byte_valid_i = 1'b1; byte_ctx_i = 2'd0; byte_i = mem[i]; step();
            byte_valid_i = 1'b1; byte_ctx_i = 2'd1; byte_i = 8'hA5; step();
        end
        byte_valid_i = 1'b0;
        chk(ctx_en_o == 4'b1001, "R6 enables independent", 32'(ctx_en_o), 32'h9);
        do_read(3, code);
        chk(code == 24'hFFFFFF, "R6 other context untouched", 32'(code), 32'hFFFFFF);
        do_read(0, code);
        exp = model_code(32);
        chk(code == exp, "R6 interleaved context code", 32'(code), 32'(exp));

        // R5: read and restart in one cycle
        fill(33);
        do_start(2);
        send(2, 50);
        rd_i = 1'b1; rd_ctx_i = 2'd2; start_i = 1'b1; start_ctx_i = 2'd2;
        step();
        rd_i = 1'b0; start_i = 1'b0;
        exp = model_code(50);
        chk(rd_code_o == exp, "R5 read with restart returns old", 32'(rd_code_o), 32'(exp));
        chk(ctx_en_o[2] == 1'b1, "R5 restart wins enable", 32'(ctx_en_o), 32'h4);
        do_read(2, code);
        chk(code == 24'hFFFFFF, "R5 context empty after restart", 32'(code), 32'hFFFFFF);

        // R5: byte in the read cycle is dropped
        do_start(3);
        send(3, 10);
        byte_valid_i = 1'b1; byte_ctx_i = 2'd3; byte_i = 8'h5A;
        rd_i = 1'b1; rd_ctx_i = 2'd3;
        step();
        rd_i = 1'b0; byte_valid_i = 1'b0;
        exp = model_code(10);
        chk(rd_code_o == exp, "R5 same cycle byte dropped", 32'(rd_code_o), 32'(exp));
        do_read(3, code);
        chk(code == 24'hFFFFFF, "R5 cleared after read", 32'(code), 32'hFFFFFF);

        // R7: zero syndrome
        cmp_and_check("R7 zero syndrome", 24'h123456, 24'h123456);
        // R8: every correctable index
        for (int idx = 0; idx < 4096; idx++) begin
            logic [23:0] st_c = 24'(idx * 7919 + 12345);
            cmp_and_check("R8 correctable sweep", st_c, st_c ^ {12'(idx), ~12'(idx)});
        end
        // R9: every one-hot syndrome
        for (int k = 0; k < 24; k++)
            cmp_and_check("R9 code bit error", 24'hFFFFFF, 24'hFFFFFF ^ (24'd1 << k));
        // R10: two-bit and scattered syndromes
        for (int k = 0; k < 23; k++)
            cmp_and_check("R10 two-bit syndrome", 24'h0, 24'h3 << k);
        for (int k = 1; k < 200; k++)
            cmp_and_check("R10 scattered syndrome", 24'(k * 104729), 24'(k * 15485863));

        // R8: end to end single flip recovery
        fill(77);
        do_start(1); send(1, 512); do_read(1, c0);
        exp = model_code(512);
        chk(c0 == exp, "R2 full unit code", 32'(c0), 32'(exp));
        mem[300][5] = ~mem[300][5];
        do_start(1); send(1, 512); do_read(1, c1);
        do_cmp(c0, c1);
        chk(cmp_status_o == 2'd1, "R8 end-to-end status", 32'(cmp_status_o), 32'd1);
        chk(cmp_byte_o == 9'd300, "R8 end-to-end byte", 32'(cmp_byte_o), 32'd300);
        chk(cmp_bit_o == 3'd5, "R8 end-to-end bit", 32'(cmp_bit_o), 32'd5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule